// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory channel and takes the DRAM from its power-up condition to a state where normal traffic may begin. It drives clock enable, on-die termination, the four command strobes (chip select, row strobe, column strobe, write enable), the bank address and the row/column address lines. The walk through waits and commands is fixed. It holds a long NOP-only settling period with clock enable low. It then raises clock enable and waits a short guard time. Next come a precharge of all banks, the writes to the three extended mode registers and a mode register write that resets the DLL, followed by the DLL lock wait. The walk ends with a second precharge of all banks, a programmable number of refreshes and one dummy write.

Every wait is a cycle count. The two long waits are given in nanoseconds and turned into cycles from a clock-period parameter, rounding up so that no minimum is cut short. The command-to-command gaps (mode register set, precharge, refresh, write recovery) are given directly in cycles. Each command lasts one cycle and is followed by NOP cycles for its gap. After the final recovery gap, a done flag rises and stays high until reset. The system raises the power-good input once supplies and clock are stable. It holds the sequencer in reset to restart it.

States: IDLE (waiting for power-good), PWR_WAIT (settling, clock enable low), CKE_WAIT (clock enable high, guard time), PRE_A (first precharge all), LMR_E2, LMR_E3, LMR_E1 (extended mode register writes), LMR_MR (mode register with DLL reset plus lock wait), PRE_B (second precharge all), REFRESH (repeated), DUMMY_WR, READY. Transitions: IDLE to PWR_WAIT when power-good is sampled high. Each later state moves to the next one in the listed order when its cycle count expires. REFRESH re-enters itself until its repeat count is used up. READY is terminal. Reset from any state returns to IDLE.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: The ODT output is 0 in every cycle, from reset through READY.
- R2: While in reset, and in IDLE while pwr_ok is low, CKE is 0, init_done is 0, and the command {cs_n,ras_n,cas_n,we_n} is NOP = 4'b0111 with ba and addr all zero.
- R3: The cycle after pwr_ok is sampled high starts ceil(STABLE_NS*1000/CLK_PS) cycles of NOP with CKE 0 (40000 at defaults). Then CKE goes to 1 and ceil(CKE_NS*1000/CLK_PS) NOP cycles follow (80 at defaults).
- R4: The first precharge-all is one cycle of command 4'b0010 with addr bit 10 at 1, all other addr bits 0 and ba 0. It is followed by T_RP NOP cycles.
- R5: The EMR(2) write is command 4'b0000 (load mode) with ba = 2 (BA1=1, BA0=0) and addr = EMR2_VALUE. It is followed by T_MRD NOP cycles.
- R6: The EMR(3) write is command 4'b0000 with ba = 3 and addr = EMR3_VALUE. It is followed by T_MRD NOP cycles.
- R7: The EMR(1) write is command 4'b0000 with ba = 1 and addr = EMR1_VALUE with bits 0, 7, 8 and 9 forced to 0 (DLL enabled). It is followed by T_MRD NOP cycles.
- R8: The mode register write is command 4'b0000 with ba = 0 and addr = MR_VALUE with bit 8 forced to 1 (DLL reset). It is followed by max(DLL_LOCK, T_MRD) NOP cycles (200 at defaults).
- R9: A second precharge-all, encoded as in R4, follows the DLL lock wait. It is followed by T_RP NOP cycles.
- R10: REF_COUNT (at least 2) refresh commands follow, each 4'b0001 with ba and addr 0 and each followed by T_RFC NOP cycles.
- R11: A single dummy write follows, 4'b0100 with ba 0 and addr 0. It is followed by T_WR NOP cycles.
- R12: init_done rises in the cycle after the last write recovery cycle and stays 1 until reset. CKE stays 1 from its rise until reset, and only NOP is driven in READY.
- R13: Asserting reset at any point returns at once to the R2 state. A following run repeats the whole sequence from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PS |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock are stable |
| cke | output | 1 | DRAM clock enable |
| odt | output | 1 | DRAM on-die termination control |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/column address lines |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
The assertions assume that pwr_ok, once raised, stays high until the next reset. They also assume that every gap parameter is at least 1, so that a command is always followed by a NOP. The bench respects both: it raises pwr_ok only after a stretch of low cycles, keeps it high for the rest of a run, and drops it only while reset is held. The bench's reference model builds the expected per-cycle pin values from the requirements alone. It compares every cycle of a run that is cut off by reset inside the DLL lock wait, then every cycle of a full run through READY.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_WAIT,
        ST_CKE_WAIT,
        ST_PRE_A,
        ST_LMR_E2,
        ST_LMR_E3,
        ST_LMR_E1,
        ST_LMR_MR,
        ST_PRE_B,
        ST_REFRESH,
        ST_DUMMY_WR,
        ST_READY
    } init_state_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_PRE_ALL,
        K_LOAD_MODE,
        K_REFRESH,
        K_WRITE
    } cmd_kind_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_NOP       = 4'b0111;
    localparam logic [3:0] PIN_PRECHARGE = 4'b0010;
    localparam logic [3:0] PIN_REFRESH   = 4'b0001;
    localparam logic [3:0] PIN_LOAD_MODE = 4'b0000;
    localparam logic [3:0] PIN_WRITE     = 4'b0100;

    // bank-address selectors of the mode registers
    localparam logic [1:0] SEL_MR   = 2'b00;
    localparam logic [1:0] SEL_EMR1 = 2'b01;
    localparam logic [1:0] SEL_EMR2 = 2'b10;
    localparam logic [1:0] SEL_EMR3 = 2'b11;

    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/ddr2_cmd_drive.sv
module ddr2_cmd_drive
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2
) (
    input  cmd_kind_t         kind,
    input  logic [BANK_W-1:0] ba_in,
    input  logic [ROW_W-1:0]  addr_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr
);

    localparam int AP_BIT = 10;

    logic [3:0] pins;

    always_comb begin
        pins = PIN_NOP;
        ba   = '0;
        addr = '0;
        unique case (kind)
            K_NOP: begin
                pins = PIN_NOP;
            end
            K_PRE_ALL: begin
                pins         = PIN_PRECHARGE;
                addr[AP_BIT] = 1'b1;
            end
            K_LOAD_MODE: begin
                pins = PIN_LOAD_MODE;
                ba   = ba_in;
                addr = addr_in;
            end
            K_REFRESH: begin
                pins = PIN_REFRESH;
            end
            K_WRITE: begin
                pins = PIN_WRITE;
                ba   = ba_in;
                addr = addr_in;
            end
            default: begin
                pins = PIN_NOP;
            end
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins;

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_PS    = 5000,
    parameter int STABLE_NS = 200000,
    parameter int CKE_NS    = 400,
    parameter int T_MRD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 26,
    parameter int T_WR      = 10,
    parameter int DLL_LOCK  = 200,
    parameter int REF_COUNT = 2,
    parameter int ROW_W     = 14,
    parameter int BANK_W    = 2,
    parameter logic [ROW_W-1:0] MR_VALUE   = '0,
    parameter logic [ROW_W-1:0] EMR1_VALUE = '0,
    parameter logic [ROW_W-1:0] EMR2_VALUE = '0,
    parameter logic [ROW_W-1:0] EMR3_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);

    // state durations, command cycle included
    localparam int STABLE_CYC = ns_to_cycles(STABLE_NS, CLK_PS);
    localparam int CKE_CYC    = ns_to_cycles(CKE_NS, CLK_PS);
    localparam int PRE_DUR    = 1 + T_RP;
    localparam int LMR_DUR    = 1 + T_MRD;
    localparam int DLL_DUR    = 1 + imax(DLL_LOCK, T_MRD);
    localparam int REF_DUR    = 1 + T_RFC;
    localparam int WR_DUR     = 1 + T_WR;
    localparam int MAX_DUR    = imax(imax(imax(STABLE_CYC, CKE_CYC), imax(PRE_DUR, LMR_DUR)),
                                     imax(imax(DLL_DUR, REF_DUR), WR_DUR));
    localparam int CNT_W      = $clog2(MAX_DUR + 1);
    localparam int REF_W      = $clog2(REF_COUNT + 1);

    // mode values with the fixed fields applied
    localparam logic [ROW_W-1:0] EMR1_MASK = ROW_W'(14'h0381);
    localparam logic [ROW_W-1:0] EMR1_EFF  = EMR1_VALUE & ~EMR1_MASK;
    localparam logic [ROW_W-1:0] MR_EFF    = MR_VALUE | (ROW_W'(1) << 8);

    init_state_t       state_q, state_d;
    logic              first_q;
    logic              adv;
    logic [CNT_W-1:0]  load_val;
    logic              expired;
    logic [REF_W-1:0]  ref_left_q;

    cmd_kind_t         kind;
    logic [BANK_W-1:0] ba_sel;
    logic [ROW_W-1:0]  addr_sel;

    ddr2_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (load_val),
        .expired  (expired)
    );

    // next-state and timer load
    always_comb begin
        state_d  = state_q;
        adv      = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_ok) begin
                    state_d  = ST_PWR_WAIT;
                    adv      = 1'b1;
                    load_val = CNT_W'(STABLE_CYC - 1);
                end
            end
            ST_PWR_WAIT: begin
                if (expired) begin
                    state_d  = ST_CKE_WAIT;
                    adv      = 1'b1;
                    load_val = CNT_W'(CKE_CYC - 1);
                end
            end
            ST_CKE_WAIT: begin
                if (expired) begin
                    state_d  = ST_PRE_A;
                    adv      = 1'b1;
                    load_val = CNT_W'(PRE_DUR - 1);
                end
            end
            ST_PRE_A: begin
                if (expired) begin
                    state_d  = ST_LMR_E2;
                    adv      = 1'b1;
                    load_val = CNT_W'(LMR_DUR - 1);
                end
            end
            ST_LMR_E2: begin
                if (expired) begin
                    state_d  = ST_LMR_E3;
                    adv      = 1'b1;
                    load_val = CNT_W'(LMR_DUR - 1);
                end
            end
            ST_LMR_E3: begin
                if (expired) begin
                    state_d  = ST_LMR_E1;
                    adv      = 1'b1;
                    load_val = CNT_W'(LMR_DUR - 1);
                end
            end
            ST_LMR_E1: begin
                if (expired) begin
                    state_d  = ST_LMR_MR;
                    adv      = 1'b1;
                    load_val = CNT_W'(DLL_DUR - 1);
                end
            end
            ST_LMR_MR: begin
                if (expired) begin
                    state_d  = ST_PRE_B;
                    adv      = 1'b1;
                    load_val = CNT_W'(PRE_DUR - 1);
                end
            end
            ST_PRE_B: begin
                if (expired) begin
                    state_d  = ST_REFRESH;
                    adv      = 1'b1;
                    load_val = CNT_W'(REF_DUR - 1);
                end
            end
            ST_REFRESH: begin
                if (expired) begin
                    adv = 1'b1;
                    if (ref_left_q == REF_W'(1)) begin
                        state_d  = ST_DUMMY_WR;
                        load_val = CNT_W'(WR_DUR - 1);
                    end else begin
                        state_d  = ST_REFRESH;
                        load_val = CNT_W'(REF_DUR - 1);
                    end
                end
            end
            ST_DUMMY_WR: begin
                if (expired) begin
                    state_d = ST_READY;
                    adv     = 1'b1;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            first_q    <= 1'b0;
            ref_left_q <= '0;
        end else begin
            state_q <= state_d;
            first_q <= adv;
            if (state_q == ST_PRE_B) begin
                ref_left_q <= REF_W'(REF_COUNT);
            end else if (state_q == ST_REFRESH && expired) begin
                ref_left_q <= ref_left_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cke       = 1'b1;
        init_done = 1'b0;
        kind      = K_NOP;
        ba_sel    = '0;
        addr_sel  = '0;
        unique case (state_q)
            ST_IDLE, ST_PWR_WAIT: begin
                cke = 1'b0;
            end
            ST_CKE_WAIT: begin
                kind = K_NOP;
            end
            ST_PRE_A, ST_PRE_B: begin
                if (first_q) kind = K_PRE_ALL;
            end
            ST_LMR_E2: begin
                if (first_q) begin
                    kind     = K_LOAD_MODE;
                    ba_sel   = BANK_W'(SEL_EMR2);
                    addr_sel = EMR2_VALUE;
                end
            end
            ST_LMR_E3: begin
                if (first_q) begin
                    kind     = K_LOAD_MODE;
                    ba_sel   = BANK_W'(SEL_EMR3);
                    addr_sel = EMR3_VALUE;
                end
            end
            ST_LMR_E1: begin
                if (first_q) begin
                    kind     = K_LOAD_MODE;
                    ba_sel   = BANK_W'(SEL_EMR1);
                    addr_sel = EMR1_EFF;
                end
            end
            ST_LMR_MR: begin
                if (first_q) begin
                    kind     = K_LOAD_MODE;
                    ba_sel   = BANK_W'(SEL_MR);
                    addr_sel = MR_EFF;
                end
            end
            ST_REFRESH: begin
                if (first_q) kind = K_REFRESH;
            end
            ST_DUMMY_WR: begin
                if (first_q) kind = K_WRITE;
            end
            ST_READY: begin
                init_done = 1'b1;
            end
            default: begin
                cke = 1'b0;
            end
        endcase
    end

    assign odt = 1'b0;

    ddr2_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_drive (
        .kind    (kind),
        .ba_in   (ba_sel),
        .addr_in (addr_sel),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .addr    (addr)
    );

endmodule

// File: rtl/ddr2_bringup_checker.sv
module ddr2_bringup_checker #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              cke,
    input logic              odt,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ROW_W-1:0]  addr,
    input logic              init_done
);

    logic [3:0] pins;
    logic       is_nop;
    logic       is_lmr;
    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_lmr = (pins == 4'b0000);

    p_odt_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        odt == 1'b0);

    p_no_start_without_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !pwr_ok) |=> !cke);

    p_cke_low_only_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    p_precharge_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> (addr[10] && ba == '0));

    p_gap_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    p_emr1_dll_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lmr && ba == BANK_W'(1)) |-> (addr[0] == 1'b0 && addr[9:7] == 3'b000));

    p_mr_dll_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lmr && ba == BANK_W'(0)) |-> addr[8]);

    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_cke_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && is_nop));

endmodule

bind ddr2_bringup_seq ddr2_bringup_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .cke       (cke),
    .odt       (odt),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr2_bringup_seq_bench.sv
`timescale 1ns/1ps
module ddr2_bringup_seq_bench;

    localparam int ROW_W  = 14;
    localparam int BANK_W = 2;
    localparam int CLK_PS = 5000;
    localparam int STABLE_NS = 200000;
    localparam int CKE_NS = 400;
    localparam int T_MRD = 2;
    localparam int T_RP = 3;
    localparam int T_RFC = 26;
    localparam int T_WR = 10;
    localparam int DLL_LOCK = 200;
    localparam int REF_COUNT = 3;
    localparam logic [ROW_W-1:0] MR_V   = 14'h0A63;
    localparam logic [ROW_W-1:0] EMR1_V = 14'h03C7;
    localparam logic [ROW_W-1:0] EMR2_V = 14'h0080;
    localparam logic [ROW_W-1:0] EMR3_V = 14'h0005;

    typedef struct packed {
        logic              cke;
        logic [3:0]        cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  addr;
        logic              done;
        logic [7:0]        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, pwr_ok;
    logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0]  addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ddr2_bringup_seq #(
        .CLK_PS(CLK_PS), .STABLE_NS(STABLE_NS), .CKE_NS(CKE_NS),
        .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR),
        .DLL_LOCK(DLL_LOCK), .REF_COUNT(REF_COUNT),
        .ROW_W(ROW_W), .BANK_W(BANK_W),
        .MR_VALUE(MR_V), .EMR1_VALUE(EMR1_V), .EMR2_VALUE(EMR2_V), .EMR3_VALUE(EMR3_V)
    ) u_ddr2_bringup_seq (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            13: return "R13";
            default: return "R?";
        endcase
    endfunction

    task automatic push(input logic c, input logic [3:0] cmd, input int b,
                        input logic [ROW_W-1:0] a, input logic d, input int t);
        exp_t e;
        e.cke = c; e.cmd = cmd; e.ba = BANK_W'(b); e.addr = a; e.done = d; e.tag = 8'(t);
        q.push_back(e);
    endtask

    task automatic push_nops(input int n, input logic c, input int t);
        for (int i = 0; i < n; i++) push(c, 4'b0111, 0, '0, 1'b0, t);
    endtask

    // expected waveform from the requirements
    task automatic build_run();
        int stable = (STABLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
        int guard  = (CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
        q.delete();
        push_nops(stable, 1'b0, 3);
        push_nops(guard, 1'b1, 3);
        push(1'b1, 4'b0010, 0, 14'h0400, 1'b0, 4);              // R4
        push_nops(T_RP, 1'b1, 4);
        push(1'b1, 4'b0000, 2, EMR2_V, 1'b0, 5);                // R5
        push_nops(T_MRD, 1'b1, 5);
        push(1'b1, 4'b0000, 3, EMR3_V, 1'b0, 6);                // R6
        push_nops(T_MRD, 1'b1, 6);
        push(1'b1, 4'b0000, 1, 14'h0046, 1'b0, 7);              // R7: 03C7 with 0,7,8,9 cleared
        push_nops(T_MRD, 1'b1, 7);
        push(1'b1, 4'b0000, 0, 14'h0B63, 1'b0, 8);              // R8: 0A63 with bit 8 set
        push_nops((DLL_LOCK > T_MRD) ? DLL_LOCK : T_MRD, 1'b1, 8);
        push(1'b1, 4'b0010, 0, 14'h0400, 1'b0, 9);              // R9
        push_nops(T_RP, 1'b1, 9);
        for (int r = 0; r < REF_COUNT; r++) begin               // R10
            push(1'b1, 4'b0001, 0, '0, 1'b0, 10);
            push_nops(T_RFC, 1'b1, 10);
        end
        push(1'b1, 4'b0100, 0, '0, 1'b0, 11);                   // R11
        push_nops(T_WR, 1'b1, 11);
        for (int i = 0; i < 60; i++) push(1'b1, 4'b0111, 0, '0, 1'b1, 12); // R12
    endtask

    task automatic compare(input exp_t e);
        logic [3:0] got_cmd;
        got_cmd = {cs_n, ras_n, cas_n, we_n};
        checks++;
        if (cke !== e.cke || got_cmd !== e.cmd || ba !== e.ba || addr !== e.addr
            || init_done !== e.done) begin
            errors++;
            $display("FAIL %s t=%0t: cke/cmd/ba/addr/done = %b/%b/%0d/%h/%b expected %b/%b/%0d/%h/%b",
                     tag_name(int'(e.tag)), $time, cke, got_cmd, ba, addr, init_done,
                     e.cke, e.cmd, e.ba, e.addr, e.done);
        end
        checks++;
        if (odt !== 1'b0) begin
            errors++;
            $display("FAIL R1 t=%0t: odt = %b expected 0", $time, odt);
        end
    endtask

    function automatic exp_t idle_exp(input int t);
        exp_t e;
        e.cke = 1'b0; e.cmd = 4'b0111; e.ba = '0; e.addr = '0; e.done = 1'b0; e.tag = 8'(t);
        return e;
    endfunction

    initial begin
        rst_n = 1'b0;
        pwr_ok = 1'b0;
        repeat (3) @(negedge clk);
        compare(idle_exp(2));                 // R2: reset state
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin     // R2: idle while power not good
            @(negedge clk);
            compare(idle_exp(2));
        end
        // first run, cut off by reset inside the DLL lock wait
        build_run();
        pwr_ok = 1'b1;
        for (int i = 0; i < 40200; i++) begin
            @(negedge clk);
            compare(q.pop_front());
        end
        rst_n = 1'b0;                          // R13
        pwr_ok = 1'b0;
        #1;
        compare(idle_exp(13));
        @(negedge clk);
        compare(idle_exp(13));
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            compare(idle_exp(13));
        end
        // full run
        build_run();
        pwr_ok = 1'b1;
        while (q.size() > 0) begin
            @(negedge clk);
            compare(q.pop_front());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule